// File: doc/BRIEF.md
# Byte-Wide Host Port with Word Packing and Command Request

This block joins an external host processor, whose strobes are not tied to any clock of the chip, to a 16-bit processor core. The host sees a small byte-wide register window. It writes a high and a low byte that the block packs into one 16-bit word for the core. It reads a high and a low byte that the block unpacks from a word the core has written. Empty and full flags guard each direction, so that neither side overwrites data the other has not yet consumed.

The host can also raise a command request toward the core and supply an exception vector with it. The vector is locked while the request is pending. The host may withdraw the request until the core acknowledges it. Two flag bits driven by the core appear in the host's status byte. An interrupt line tells the host when a byte pair is ready to read or the transmit pair is free.

Host read and write strobes are active low. Each passes through a two-flop synchronizer into the core clock domain. A write takes effect on the synchronized assertion of its strobe. A read's side effect takes place on the synchronized release of its strobe. The host must hold address and data steady for the whole strobe and for three core cycles after a read strobe is released. Read data is a plain multiplexer over registers, so the host never waits for the core clock.

Top module: `host_byte_port`

Host register window (`host_addr`):

| Address | Write | Read |
|---|---|---|
| 0 | interrupt enables | interrupt enables |
| 1 | command bit and vector | command bit and vector |
| 2 | none | status byte |
| 4 | transmit high byte | receive high byte |
| 5 | transmit low byte | receive low byte |

- Address 0 holds two enables: bit 0 enables the receive-full interrupt and bit 1 enables the transmit-empty interrupt.
- Address 1 holds the command bit in bit 7 and the 7-bit vector in bits 6:0.
- The status byte at address 2 is laid out as follows: bit 0 is receive-full, bit 1 is transmit-empty, bit 2 is transmit-ready, bits 4:3 are the core flags (core_flags[1:0]), bit 5 is the interrupt line, bit 6 is the command pending bit and bit 7 is zero.
- All other addresses read as zero.

## Requirements
- R1: After reset, transmit-empty is 1, receive-full is 0, the command bit is 0, both core flags in the status byte are 0, core_rx_valid is 0 and core_tx_full is 0.
- R2: Writing address 4 and then address 5 clears transmit-empty. When the core word is empty, the word {high, low} then appears on core_rx_data with core_rx_valid set, and transmit-empty returns to 1.
- R3: While core_rx_valid is set and core_rx_take has not been pulsed, core_rx_data holds its value and newly written host bytes wait. During this time transmit-empty stays 0, and transmit-ready (status bit 2, which is transmit-empty AND NOT core_rx_valid) is 0.
- R4: A core_tx_write while core_tx_full is 0 captures core_tx_data. If receive-full is 0, the word moves into the receive byte pair, with bits 15:8 at address 4 and bits 7:0 at address 5. Receive-full is set and core_tx_full clears. Otherwise core_tx_full stays 1.
- R5: Completing a host read of address 5 clears receive-full. A word held by the core then moves in. While receive-full is set, the receive bytes do not change.
- R6: Writing 1 to bit 7 of address 1 asserts cmd_req. The request holds until the core pulses cmd_ack or the host writes the bit back to 0.
- R7: Writing 0 to bit 7 of address 1 while a request is pending withdraws cmd_req.
- R8: A write to address 1 updates the vector (bits 6:0) only when the command bit was 0 before the write. Otherwise the vector is ignored, and cmd_vec stays stable while cmd_req is set.
- R9: core_flags are registered into status bits 4:3 one core clock after they change.
- R10: host_irq is 1 exactly when (receive-full AND enable bit 0) OR (transmit-empty AND enable bit 1).
- R11: host_rdata shows the addressed register at once, without waiting on a core clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst_n | input | 1 | active-low reset |
| host_addr | input | 3 | host register address |
| host_wdata | input | 8 | host write byte |
| host_wr_n | input | 1 | host write strobe, active low, asynchronous |
| host_rd_n | input | 1 | host read strobe, active low, asynchronous |
| host_rdata | output | 8 | host read byte |
| host_irq | output | 1 | host interrupt request |
| core_rx_data | output | 16 | packed word for the core |
| core_rx_valid | output | 1 | core word holds unread data |
| core_rx_take | input | 1 | core has consumed the word |
| core_tx_data | input | 16 | word from the core for the host |
| core_tx_write | input | 1 | core writes a word |
| core_tx_full | output | 1 | core-to-host word not yet unpacked |
| core_flags | input | 2 | flag bits shown to the host |
| cmd_req | output | 1 | command request to the core |
| cmd_vec | output | 7 | vector for the command request |
| cmd_ack | input | 1 | core has latched the request |

## Verification
Every cycle, the assertions check several holding behaviours:
- the core word is not overrun before it is taken;
- the receive bytes are not disturbed while full;
- a pending command is not dropped without an acknowledge or a host clear;
- the vector is frozen under a pending request;
- a held core word waits while the receive pair is full.

Only the bench scenarios can show the following:
- correct byte order in packing and unpacking;
- the exact moment the flags return after a consumer acts;
- cancellation followed by a fresh vector;
- the interrupt enable combinations.

// File: rtl/host_byte_port.sv
module host_byte_port (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  host_addr,
  input  logic [7:0]  host_wdata,
  input  logic        host_wr_n,
  input  logic        host_rd_n,
  output logic [7:0]  host_rdata,
  output logic        host_irq,
  output logic [15:0] core_rx_data,
  output logic        core_rx_valid,
  input  logic        core_rx_take,
  input  logic [15:0] core_tx_data,
  input  logic        core_tx_write,
  output logic        core_tx_full,
  input  logic [1:0]  core_flags,
  output logic        cmd_req,
  output logic [6:0]  cmd_vec,
  input  logic        cmd_ack
);
  localparam logic [2:0] A_CTL = 3'd0, A_CMD = 3'd1, A_STAT = 3'd2,
                         A_HI = 3'd4, A_LO = 3'd5;

  logic [2:0]  wr_s, rd_s;
  logic [1:0]  ien, hf;
  logic        hc, txde, rxdf, crx_full, ctx_full;
  logic [7:0]  txh, txl, rxh, rxl;
  logic [15:0] crx, ctx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_s <= 3'b111;
      rd_s <= 3'b111;
    end else begin
      wr_s <= {wr_s[1:0], host_wr_n};
      rd_s <= {rd_s[1:0], host_rd_n};
    end

  wire wr_fire = wr_s[2] & ~wr_s[1];
  wire rd_done = ~rd_s[2] & rd_s[1];
  wire wr_ctl  = wr_fire && host_addr == A_CTL;
  wire wr_cmd  = wr_fire && host_addr == A_CMD;
  wire wr_hi   = wr_fire && host_addr == A_HI;
  wire wr_lo   = wr_fire && host_addr == A_LO;
  wire rd_lo   = rd_done && host_addr == A_LO;
  wire tx_go   = ~txde & ~crx_full;
  wire rx_go   = ctx_full & ~rxdf;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ien <= '0; hf <= '0; hc <= 1'b0; cmd_vec <= '0;
      txh <= '0; txl <= '0; txde <= 1'b1;
      rxh <= '0; rxl <= '0; rxdf <= 1'b0;
      crx <= '0; crx_full <= 1'b0; ctx <= '0; ctx_full <= 1'b0;
    end else begin
      hf <= core_flags;
      if (wr_ctl) ien <= host_wdata[1:0];
      if (cmd_ack && hc) hc <= 1'b0;
      if (wr_cmd) begin
        hc <= host_wdata[7];
        if (!hc) cmd_vec <= host_wdata[6:0];
      end
      if (core_rx_take) crx_full <= 1'b0;
      if (tx_go) begin
        crx <= {txh, txl};
        crx_full <= 1'b1;
        txde <= 1'b1;
      end
      if (wr_hi) txh <= host_wdata;
      if (wr_lo) begin
        txl <= host_wdata;
        txde <= 1'b0;
      end
      if (core_tx_write && !ctx_full) begin
        ctx <= core_tx_data;
        ctx_full <= 1'b1;
      end
      if (rx_go) begin
        {rxh, rxl} <= ctx;
        rxdf <= 1'b1;
        ctx_full <= 1'b0;
      end
      if (rd_lo) rxdf <= 1'b0;
    end

  assign core_rx_data  = crx;
  assign core_rx_valid = crx_full;
  assign core_tx_full  = ctx_full;
  assign cmd_req       = hc;
  assign host_irq      = (rxdf & ien[0]) | (txde & ien[1]);

  always_comb
    case (host_addr)
      A_CTL:   host_rdata = {6'b0, ien};
      A_CMD:   host_rdata = {hc, cmd_vec};
      A_STAT:  host_rdata = {1'b0, hc, host_irq, hf, txde & ~crx_full, txde, rxdf};
      A_HI:    host_rdata = rxh;
      A_LO:    host_rdata = rxl;
      default: host_rdata = 8'h00;
    endcase

  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    core_rx_valid && !core_rx_take |=> core_rx_valid && $stable(core_rx_data)); // R3
  AST_CORE_WORD_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    core_tx_full && rxdf && !rd_lo |=> core_tx_full); // R4
  AST_RX_BYTES_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    rxdf && !rd_lo |=> rxdf && $stable({rxh, rxl})); // R5
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req && !cmd_ack && !wr_cmd |=> cmd_req); // R6
  AST_VEC_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req |=> $stable(cmd_vec)); // R8
endmodule

// File: tb/host_byte_port_bench.sv
module host_byte_port_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] host_addr = '0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic host_wr_n = 1'b1, host_rd_n = 1'b1, host_irq;
  logic [15:0] core_rx_data, core_tx_data = '0;
  logic core_rx_valid, core_rx_take = 1'b0, core_tx_write = 1'b0, core_tx_full;
  logic [1:0] core_flags = '0;
  logic cmd_req, cmd_ack = 1'b0;
  logic [6:0] cmd_vec;
  int checks = 0, errs = 0;

  always #5 clk = ~clk;

  host_byte_port u_host_byte_port (.*);

  function automatic logic [15:0] pack(input logic [7:0] h, input logic [7:0] l);
    return {h, l};
  endfunction
  function automatic logic irq_exp(input logic [1:0] en, input logic rf, input logic te);
    return (rf & en[0]) | (te & en[1]);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hwrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr_n = 1'b0;
    repeat (5) @(negedge clk); host_wr_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic hread(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); host_addr = a; host_rd_n = 1'b0;
    #1 d = host_rdata;
    repeat (4) @(negedge clk); host_rd_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic cpush(input logic [15:0] w);
    @(negedge clk); core_tx_data = w; core_tx_write = 1'b1;
    @(negedge clk); core_tx_write = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic ctake();
    @(negedge clk); core_rx_take = 1'b1;
    @(negedge clk); core_rx_take = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic cack();
    @(negedge clk); cmd_ack = 1'b1;
    @(negedge clk); cmd_ack = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    logic [7:0] st, h, l;
    logic [15:0] w;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    hread(3'd2, st);
    check("R1 status", st, 8'h06);
    check("R1 core_rx_valid", core_rx_valid, 1'b0);
    check("R1 core_tx_full", core_tx_full, 1'b0);
    check("R1 cmd_req", cmd_req, 1'b0);

    hwrite(3'd4, 8'hA5);
    hwrite(3'd5, 8'h3C);
    check("R2 directed word", core_rx_data, 16'hA53C);
    check("R2 valid", core_rx_valid, 1'b1);
    hread(3'd2, st);
    check("R2 txde back", st[1], 1'b1);
    check("R3 trdy low while core word full", st[2], 1'b0);

    hwrite(3'd4, 8'h11);
    hwrite(3'd5, 8'h22);
    hread(3'd2, st);
    check("R3 txde held", st[1], 1'b0);
    check("R3 word held", core_rx_data, 16'hA53C);
    ctake();
    check("R3 waiting pair moves after take", core_rx_data, 16'h1122);
    hread(3'd2, st);
    check("R3 txde after take", st[1], 1'b1);
    ctake();
    hread(3'd2, st);
    check("R3 trdy when all empty", st[2], 1'b1);

    for (int i = 0; i < 12; i++) begin
      h = 8'($urandom); l = 8'($urandom);
      hwrite(3'd4, h);
      hwrite(3'd5, l);
      check("R2 random pack", core_rx_data, pack(h, l));
      ctake();
    end

    cpush(16'hBEEF);
    check("R4 core_tx_full cleared", core_tx_full, 1'b0);
    cpush(16'h1357);
    check("R4 core word waits", core_tx_full, 1'b1);
    hread(3'd2, st);
    check("R4 rxdf", st[0], 1'b1);
    hread(3'd4, h);
    check("R4 high byte", h, 8'hBE);
    hread(3'd5, l);
    check("R4 low byte", l, 8'hEF);
    check("R5 pending word moved", core_tx_full, 1'b0);
    hread(3'd4, h);
    hread(3'd5, l);
    check("R5 second word", pack(h, l), 16'h1357);
    hread(3'd2, st);
    check("R5 rxdf cleared", st[0], 1'b0);

    for (int i = 0; i < 10; i++) begin
      w = 16'($urandom);
      cpush(w);
      hread(3'd4, h);
      hread(3'd5, l);
      check("R4 random unpack", pack(h, l), w);
    end

    hwrite(3'd1, 8'h85);
    check("R6 req", cmd_req, 1'b1);
    check("R6 vec", cmd_vec, 7'h05);
    hwrite(3'd1, 8'h80 | 8'h2A);
    check("R8 vec locked", cmd_vec, 7'h05);
    hwrite(3'd1, 8'h33);
    check("R7 cancel", cmd_req, 1'b0);
    check("R8 vec ignored on cancel", cmd_vec, 7'h05);
    hwrite(3'd1, 8'h33);
    check("R8 vec updates when clear", cmd_vec, 7'h33);
    hwrite(3'd1, 8'h80 | 8'h33);
    repeat (6) @(negedge clk);
    check("R6 holds without ack", cmd_req, 1'b1);
    cack();
    check("R6 ack clears", cmd_req, 1'b0);

    @(negedge clk); core_flags = 2'b10;
    @(negedge clk); @(negedge clk);
    hread(3'd2, st);
    check("R9 flags", st[4:3], 2'b10);
    core_flags = 2'b01;
    @(negedge clk); @(negedge clk);
    hread(3'd2, st);
    check("R9 flags change", st[4:3], 2'b01);

    hwrite(3'd0, 8'h02);
    check("R10 tx enable", host_irq, irq_exp(2'b10, 1'b0, 1'b1));
    hwrite(3'd0, 8'h01);
    check("R10 rx enable idle", host_irq, irq_exp(2'b01, 1'b0, 1'b1));
    cpush(16'h4242);
    check("R10 rx enable full", host_irq, irq_exp(2'b01, 1'b1, 1'b1));
    hwrite(3'd0, 8'h00);
    check("R10 disabled", host_irq, 1'b0);

    @(negedge clk); host_addr = 3'd4;
    #1 check("R11 immediate read", host_rdata, 8'h42);
    host_addr = 3'd0;
    #1 check("R11 immediate ctl read", host_rdata, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule